// File: doc/BRIEF.md
# Cascadable serial configuration PROM reader

This block is the read path of a one-time-programmable serial memory that boots an SRAM-based FPGA after power-up. The array holds 32-bit words and is streamed out one bit per rising clock edge on a three-state data line. An address counter and a bit counter track the position in the array. When the last bit has gone out, the block releases the data line and pulls its chain-enable output low, so that a second device wired to that output continues the stream without a gap.

A single combined input acts as counter reset at one level and as output enable at the other. The active level is taken from a configuration word stored one address past the top of the array. The array contents come from parameters: the word at address `a` is `(a * 32'h9E3779B1) ^ SEED`, with 32-bit wrap-around. The depth is meant to be 1134, 2048 or 4096 words.

Top module: `cfgprom_reader`

## Requirements
- R1: While the stream is running, the data line presents word `a` (value `(a*32'h9E3779B1)^SEED`) most-significant bit first. Each rising clk edge with `ce_n` low moves to the next bit. After bit 0 of a word, the stream moves on to bit 31 of word `a+1`.
- R2: `dat_oe` is 1, and `dat` is driven, only while `ce_n` is low, `rst_oe` is at its enable level, and the end of the array has not been reached. Otherwise `dat` is high-impedance and `dat_oe` is 0.
- R3: While `rst_oe` is at its reset level, both counters are cleared asynchronously. When it returns to the enable level, the stream restarts at bit 31 of word 0.
- R4: While `ce_n` is high, clock edges leave both counters unchanged. When `ce_n` goes low again, the stream resumes at the bit where it stopped.
- R5: The clock edge that ends bit 0 of word DEPTH-1 drives `ceo_n` low and clears `dat_oe` in the same cycle.
- R6: Once the end has been reached, `ceo_n` equals `ce_n`, until a reset returns `ceo_n` high. Before the end, `ceo_n` is high.
- R7: A configuration word of all zeros makes `rst_oe` an active-low reset, with high as the enable level. Any other value makes `rst_oe` an active-high reset, with low as the enable level.
- R8: After the end, further clocks neither wrap the address nor drive `dat` again until a reset.
- R9: With two devices chained (the second `ce_n` taken from the first `ceo_n`), the combined bit stream continues without a missing or repeated bit across the hand-off, and at most one device drives at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; one bit per rising edge |
| ce_n | input | 1 | Active-low chip enable; high freezes counters (standby) |
| rst_oe | input | 1 | Combined counter reset / output enable, polarity from configuration word |
| dat | output | 1 | Three-state serial data |
| dat_oe | output | 1 | High while `dat` is driven |
| ceo_n | output | 1 | Active-low chain enable for the next device |

## Verification
The bench chains two small instances and walks every bit of both arrays, checking each bit against the arithmetic fill formula. A wrong bit order or a missed word increment shows up as a data mismatch, and a late or early hand-off shows up as a gap, a repeated bit or two drivers at once. The bench pauses `ce_n` mid-word, resets mid-stream, and keeps clocking well past the end of the array. These steps catch counters that creep during standby, a reset that does not return to word 0 bit 31, and counters that wrap and drive the line again. A third instance with an all-zero configuration word confirms that the reset level is inverted, and that `ceo_n` follows `ce_n` only after the end is reached.

// File: rtl/cfgprom_pkg.sv
package cfgprom_pkg;

    localparam int WORD_W = 32;
    localparam int BIT_W  = 5;
    localparam logic [WORD_W-1:0] FILL_MUL = 32'h9E3779B1;

    // hand-off state of one device in a chain
    typedef enum logic {
        ST_STREAM = 1'b0,
        ST_PASSED = 1'b1
    } hand_e;

    // parameterised array contents
    function automatic logic [WORD_W-1:0] fill_word(input logic [WORD_W-1:0] seed,
                                                    input logic [WORD_W-1:0] idx);
        return (idx * FILL_MUL) ^ seed;
    endfunction

endpackage

// File: rtl/cfgprom_array.sv
module cfgprom_array
    import cfgprom_pkg::*;
#(
    parameter int                 DEPTH    = 1134,
    parameter logic [WORD_W-1:0]  SEED     = 32'h5A5A_0000,
    parameter logic [WORD_W-1:0]  CFG_WORD = 32'hFFFF_FFFF,
    parameter int                 AW       = $clog2(DEPTH + 1)
) (
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_word,
    output logic [WORD_W-1:0] cfg_word
);

    logic [WORD_W-1:0] mem [0:DEPTH];

    // words 0..DEPTH-1 hold data, word DEPTH holds the polarity word
    for (genvar i = 0; i <= DEPTH; i++) begin : g_cell
        if (i == DEPTH) begin : g_cfg
            assign mem[i] = CFG_WORD;
        end else begin : g_data
            assign mem[i] = fill_word(SEED, WORD_W'(i));
        end
    end

    always_comb begin
        if (rd_addr <= AW'(DEPTH)) rd_word = mem[rd_addr];
        else                       rd_word = '0;
    end

    assign cfg_word = mem[DEPTH];

endmodule

// File: rtl/cfgprom_seq.sv
module cfgprom_seq
    import cfgprom_pkg::*;
#(
    parameter int DEPTH = 1134,
    parameter int AW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             ce_n,
    output logic [AW-1:0]    addr_q,
    output logic [BIT_W-1:0] bit_q,
    output logic             done_q
);

    localparam logic [AW-1:0]    LAST    = AW'(DEPTH - 1);
    localparam logic [BIT_W-1:0] BIT_TOP = BIT_W'(WORD_W - 1);

    typedef struct packed {
        logic [AW-1:0]    addr;
        logic [BIT_W-1:0] bitn;
        hand_e            st;
    } seq_t;

    localparam seq_t SEQ_RST = '{addr: '0, bitn: '0, st: ST_STREAM};

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!ce_n && s_q.st == ST_STREAM) begin
            if (s_q.bitn == BIT_TOP) begin
                s_d.bitn = '0;
                if (s_q.addr == LAST) s_d.st   = ST_PASSED;  // saturate, no wrap
                else                  s_d.addr = s_q.addr + 1'b1;
            end else begin
                s_d.bitn = s_q.bitn + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or posedge clr) begin
        if (clr) s_q <= SEQ_RST;
        else     s_q <= s_d;
    end

    assign addr_q = s_q.addr;
    assign bit_q  = s_q.bitn;
    assign done_q = (s_q.st == ST_PASSED);

endmodule

// File: rtl/cfgprom_reader.sv
module cfgprom_reader
    import cfgprom_pkg::*;
#(
    parameter int                DEPTH    = 1134,
    parameter logic [WORD_W-1:0] SEED     = 32'h5A5A_0000,
    parameter logic [WORD_W-1:0] CFG_WORD = 32'hFFFF_FFFF
) (
    input  logic clk,
    input  logic ce_n,
    input  logic rst_oe,
    output wire  dat,
    output logic dat_oe,
    output logic ceo_n
);

    localparam int AW = $clog2(DEPTH + 1);

    logic [WORD_W-1:0] rd_word;
    logic [WORD_W-1:0] cfg_word;
    logic [AW-1:0]     addr_q;
    logic [BIT_W-1:0]  bit_q;
    logic              done_q;
    logic              rst_hi;
    logic              clr;
    logic              cur_bit;

    cfgprom_array #(
        .DEPTH(DEPTH), .SEED(SEED), .CFG_WORD(CFG_WORD), .AW(AW)
    ) u_arr (
        .rd_addr (addr_q),
        .rd_word (rd_word),
        .cfg_word(cfg_word)
    );

    // an all-zero overflow word selects the active-low reset
    assign rst_hi = |cfg_word;
    assign clr    = (rst_oe == rst_hi);

    cfgprom_seq #(
        .DEPTH(DEPTH), .AW(AW)
    ) u_seq (
        .clk   (clk),
        .clr   (clr),
        .ce_n  (ce_n),
        .addr_q(addr_q),
        .bit_q (bit_q),
        .done_q(done_q)
    );

    // most significant bit first
    assign cur_bit = rd_word[BIT_W'(WORD_W - 1) - bit_q];
    assign dat_oe  = !ce_n && !clr && !done_q;
    assign dat     = dat_oe ? cur_bit : 1'bz;
    assign ceo_n   = !(done_q && !ce_n);

endmodule

// File: rtl/cfgprom_chk.sv
module cfgprom_chk #(
    parameter int DEPTH = 1134,
    parameter int AW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          clr,
    input logic          ce_n,
    input logic          dat_oe,
    input logic          ceo_n,
    input logic [AW-1:0] addr,
    input logic [4:0]    bitn,
    input logic          done
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    assert_bit_advance_R1: assert property (@(posedge clk) disable iff (clr)
        (!ce_n && !done && bitn != 5'd31) |=> (bitn == $past(bitn) + 5'd1) && $stable(addr));

    assert_word_advance_R1: assert property (@(posedge clk) disable iff (clr)
        (!ce_n && !done && bitn == 5'd31 && addr != LAST) |=> (bitn == 5'd0) && (addr == $past(addr) + 1'b1));

    assert_drive_needs_ce_R2: assert property (@(posedge clk) disable iff (clr)
        dat_oe |-> !ce_n);

    assert_standby_freeze_R4: assert property (@(posedge clk) disable iff (clr)
        ce_n |=> $stable(addr) && $stable(bitn) && $stable(done));

    assert_handoff_R5: assert property (@(posedge clk) disable iff (clr)
        (!ce_n && !done && bitn == 5'd31 && addr == LAST) |=> (!ceo_n && !dat_oe));

    assert_ceo_only_after_end_R6: assert property (@(posedge clk) disable iff (clr)
        !ceo_n |-> (done && !ce_n && !dat_oe));

    assert_saturate_R8: assert property (@(posedge clk) disable iff (clr)
        done |=> done && (addr == LAST) && !dat_oe);

endmodule

bind cfgprom_reader cfgprom_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
    .clk   (clk),
    .clr   (clr),
    .ce_n  (ce_n),
    .dat_oe(dat_oe),
    .ceo_n (ceo_n),
    .addr  (addr_q),
    .bitn  (bit_q),
    .done  (done_q)
);

// File: tb/sim_cfgprom_reader.sv
`timescale 1ns/1ps
module sim_cfgprom_reader;

    localparam int          D01 = 4;
    localparam int          D2  = 3;
    localparam logic [31:0] S0  = 32'h1234_5678;
    localparam logic [31:0] S1  = 32'hCAFE_0F0F;
    localparam logic [31:0] S2  = 32'h0BAD_F00D;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst = 1'b1, cen = 1'b0, rst2 = 1'b0, cen2 = 1'b1;
    wire  d0, d1, d2;
    logic oe0, oe1, oe2, ceo0, ceo1, ceo2;

    int nchk = 0, nerr = 0;

    cfgprom_reader #(.DEPTH(D01), .SEED(S0), .CFG_WORD(32'hFFFF_FFFF)) u0 (
        .clk(clk), .ce_n(cen), .rst_oe(rst), .dat(d0), .dat_oe(oe0), .ceo_n(ceo0));
    cfgprom_reader #(.DEPTH(D01), .SEED(S1), .CFG_WORD(32'hFFFF_FFFF)) u1 (
        .clk(clk), .ce_n(ceo0), .rst_oe(rst), .dat(d1), .dat_oe(oe1), .ceo_n(ceo1));
    cfgprom_reader #(.DEPTH(D2), .SEED(S2), .CFG_WORD(32'h0000_0000)) u2 (
        .clk(clk), .ce_n(cen2), .rst_oe(rst2), .dat(d2), .dat_oe(oe2), .ceo_n(ceo2));

    function automatic logic exp_bit(input logic [31:0] seed, input int a, input int b);
        logic [31:0] w;
        w = (32'(a) * 32'h9E3779B1) ^ seed;
        return w[31 - b];
    endfunction

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #5;
    endtask

    task automatic no_drive(input string req);
        chk(!oe0 && !oe1, req, "chain drivers", {30'd0, oe1, oe0}, 32'd0);
    endtask

    // check one bit of the chained stream at global index k
    task automatic chain_bit(input int k, input string req);
        int dev, a, b;
        logic e, got;
        dev = k / (D01 * 32);
        a   = (k % (D01 * 32)) / 32;
        b   = k % 32;
        e   = exp_bit(dev == 0 ? S0 : S1, a, b);
        got = oe0 ? d0 : d1;
        chk($countones({oe0, oe1}) == 1, "R9", "single driver", {30'd0, oe1, oe0}, dev == 0 ? 32'd1 : 32'd2);
        chk(got == e, req, $sformatf("bit %0d", k), {31'd0, got}, {31'd0, e});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (3) tick();
        #1;
        // reset state
        no_drive("R3");
        chk(ceo0 && ceo1, "R6", "ceo high in reset", {30'd0, ceo1, ceo0}, 32'd3);
        chk(!oe2, "R7", "u2 active-low reset holds line", {31'd0, oe2}, 32'd0);

        rst = 1'b0;
        for (int k = 0; k < 2 * D01 * 32; k++) begin
            if (k == 50) begin
                cen = 1'b1;
                #1;
                no_drive("R2");
                repeat (3) tick();
                no_drive("R4");
                cen = 1'b0;
            end
            #1;
            chain_bit(k, k < D01 * 32 ? "R1" : "R9");
            if (k == D01 * 32) begin
                chk(!ceo0 && !oe0, "R5", "first device handed off", {30'd0, oe0, ceo0}, 32'd0);
            end
            if (k == D01 * 32 - 1) begin
                chk(ceo0, "R6", "ceo high before end", {31'd0, ceo0}, 32'd1);
            end
            tick();
        end
        #1;
        no_drive("R5");
        chk(!ceo1, "R5", "second device ceo", {31'd0, ceo1}, 32'd0);
        repeat (40) tick();
        #1;
        no_drive("R8");
        chk(!ceo0 && !ceo1, "R8", "ceo stays low", {30'd0, ceo1, ceo0}, 32'd0);

        // ceo follows ce after end
        cen = 1'b1;
        #1;
        chk(ceo0 && ceo1, "R6", "ceo follows ce high", {30'd0, ceo1, ceo0}, 32'd3);
        tick();
        #1;
        chk(ceo0, "R6", "ceo high held", {31'd0, ceo0}, 32'd1);
        no_drive("R8");
        cen = 1'b0;
        #1;
        chk(!ceo0 && !ceo1, "R6", "ceo follows ce low", {30'd0, ceo1, ceo0}, 32'd0);
        no_drive("R8");

        // reset after end, then restart
        rst = 1'b1;
        #1;
        chk(ceo0 && ceo1, "R3", "reset raises ceo", {30'd0, ceo1, ceo0}, 32'd3);
        no_drive("R3");
        tick();
        rst = 1'b0;
        for (int k = 0; k < 40; k++) begin
            #1;
            chain_bit(k, "R3");
            tick();
        end
        // reset mid-stream
        rst = 1'b1;
        #1;
        no_drive("R3");
        tick();
        rst = 1'b0;
        for (int k = 0; k < 10; k++) begin
            #1;
            chain_bit(k, "R3");
            tick();
        end

        // inverted polarity instance
        cen2 = 1'b0;
        tick();
        #1;
        chk(!oe2, "R7", "low level is reset", {31'd0, oe2}, 32'd0);
        rst2 = 1'b1;
        for (int k = 0; k < D2 * 32; k++) begin
            #1;
            chk(oe2, "R7", "high level enables", {31'd0, oe2}, 32'd1);
            chk(d2 == exp_bit(S2, k / 32, k % 32), "R7", $sformatf("u2 bit %0d", k),
                {31'd0, d2}, {31'd0, exp_bit(S2, k / 32, k % 32)});
            tick();
        end
        #1;
        chk(!oe2 && !ceo2, "R5", "u2 end", {30'd0, ceo2, oe2}, 32'd0);
        rst2 = 1'b0;
        #1;
        chk(ceo2, "R7", "low level clears u2", {31'd0, ceo2}, 32'd1);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule